// File: doc/BRIEF.md
# Two-Stage Accumulator Processor Core

This core runs a small accumulator instruction set through two overlapping stages. Each cycle the fetch stage reads the word at the program counter into an instruction register and steps the counter by one. In the same cycle the execute stage decodes the word fetched one cycle earlier. Instruction and data memory sit outside the core and are reached through two combinational read ports and one write port. The integrating logic, here the testbench, loads the program before reset is released.

Only one stage ever writes a given register. The fetch stage alone updates the program counter and the instruction register. The execute stage alone updates the accumulator and a branch-target register. A taken control transfer writes its target into that register, and a small controller then enters a redirect cycle. In the redirect cycle fetch reads from the target and loads the counter with the target plus one. Execution is switched off for that cycle, so the instruction fetched by mistake has no effect.

The controller has four states. FILL is the state after reset: it fetches and does not execute, and always goes to RUN. RUN fetches and executes. It goes to REDIRECT on a taken transfer and to HALTED on a halt opcode, and otherwise stays in RUN. REDIRECT fetches from the branch target with execution off and always goes back to RUN. HALTED is a terminal state: nothing is fetched or executed until reset.

Top module: `acc_pipe_core`

## Requirements
- R1: While reset is held and in the first cycle after it, pc_out and acc_out are 0, halted is 0, imem_addr is 0 and dmem_we is 0.
- R2: In every cycle that is not a redirect and does not execute a halt, imem_addr equals pc_out and pc_out then advances by one.
- R3: Opcode 010 (instruction bits 15:13, operand address in bits 12:0) loads the accumulator with the two's-complement negation of bits 12:0 of the addressed memory word, modulo 2^13.
- R4: Opcodes 100 and 101 both subtract bits 12:0 of the addressed memory word from the accumulator, modulo 2^13.
- R5: Opcode 011 writes the accumulator, sign-extended to 16 bits, to the operand address with dmem_we high for exactly that execute cycle.
- R6: Opcode 000 transfers control to the address in bits 12:0 of the addressed memory word. The sequential instruction fetched during the transfer changes neither the accumulator nor memory.
- R7: Opcode 001 transfers control to (address of the executing instruction + 1) plus bits 12:0 of the addressed memory word, modulo 2^13.
- R8: Opcode 110 skips the following instruction when accumulator bit 12 is 1, and has no effect otherwise.
- R9: The cycle after a taken transfer is a redirect: imem_addr shows the target, dmem_we is 0, and pc_out becomes target + 1.
- R10: Opcode 111 stops fetch in its own execute cycle, so pc_out stays at the halt address + 1. halted rises on the next cycle and stays high, and from then on the accumulator, pc_out and memory do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 13 | Fetch read address |
| imem_rdata | input | 16 | Word at imem_addr, same cycle |
| dmem_addr | output | 13 | Operand address of the executing instruction |
| dmem_rdata | input | 16 | Word at dmem_addr, same cycle |
| dmem_we | output | 1 | Store strobe, memory writes on the next rising edge |
| dmem_wdata | output | 16 | Sign-extended accumulator for stores |
| acc_out | output | 13 | Accumulator |
| pc_out | output | 13 | Program counter |
| halted | output | 1 | Core has stopped |

## Verification
The checker tests several things on every cycle: the counter step in ordinary fetch cycles, that a taken transfer is always followed by a redirect that loads the target plus one, that no store happens during a redirect or after a halt, and that the halted state holds the counter and accumulator. Only the bench's programs can show that the arithmetic results are right, that the absolute, relative and skip targets are correct, that the squashed instruction really leaves no trace, and how many cycles pass before halted rises.

// File: rtl/acc_pipe_pkg.sv
package acc_pipe_pkg;

    typedef enum logic [2:0] {
        OP_JMP  = 3'b000,
        OP_JREL = 3'b001,
        OP_LDN  = 3'b010,
        OP_STO  = 3'b011,
        OP_SUBA = 3'b100,
        OP_SUBB = 3'b101,
        OP_SKN  = 3'b110,
        OP_HALT = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FILL,
        ST_RUN,
        ST_REDIR,
        ST_HALT
    } state_e;

endpackage

// File: rtl/acc_pipe_ctrl.sv
module acc_pipe_ctrl
    import acc_pipe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic halt_req,
    output logic fetch_en,
    output logic exec_en,
    output logic redirect,
    output logic halted
);

    state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  state_d = ST_RUN;
            ST_RUN: begin
                if (halt_req)  state_d = ST_HALT;
                else if (take) state_d = ST_REDIR;
            end
            ST_REDIR: state_d = ST_RUN;
            ST_HALT:  state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        fetch_en = 1'b0;
        exec_en  = 1'b0;
        redirect = 1'b0;
        halted   = 1'b0;
        unique case (state_q)
            ST_FILL:  fetch_en = 1'b1;
            ST_RUN: begin
                exec_en  = 1'b1;
                fetch_en = !halt_req;
            end
            ST_REDIR: begin
                fetch_en = 1'b1;
                redirect = 1'b1;
            end
            ST_HALT:  halted = 1'b1;
        endcase
    end

endmodule

// File: rtl/acc_pipe_fetch.sv
module acc_pipe_fetch #(
    parameter int ADDR_W = 13,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_en,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] tgt,
    input  logic [WORD_W-1:0] imem_rdata,
    output logic [ADDR_W-1:0] imem_addr,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] ir
);

    assign imem_addr = redirect ? tgt : pc;

    // sole writer of the program counter and instruction register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
            ir <= '0;
        end else if (fetch_en) begin
            ir <= imem_rdata;
            pc <= imem_addr + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/acc_pipe_exec.sv
module acc_pipe_exec
    import acc_pipe_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [WORD_W-1:0] ir,
    input  logic [ADDR_W-1:0] pc,
    input  logic [WORD_W-1:0] dmem_rdata,
    output logic [ADDR_W-1:0] dmem_addr,
    output logic              dmem_we,
    output logic [WORD_W-1:0] dmem_wdata,
    output logic [ADDR_W-1:0] acc,
    output logic [ADDR_W-1:0] tgt_q,
    output logic              take,
    output logic              halt_req
);

    localparam int OPC_W = WORD_W - ADDR_W;

    opcode_e           op;
    logic [ADDR_W-1:0] mword;
    logic [ADDR_W-1:0] acc_d;
    logic [ADDR_W-1:0] tgt_d;

    assign op         = opcode_e'(ir[WORD_W-1 -: OPC_W]);
    assign dmem_addr  = ir[ADDR_W-1:0];
    assign mword      = dmem_rdata[ADDR_W-1:0];
    assign dmem_wdata = {{OPC_W{acc[ADDR_W-1]}}, acc};

    always_comb begin
        acc_d    = acc;
        tgt_d    = tgt_q;
        take     = 1'b0;
        halt_req = 1'b0;
        dmem_we  = 1'b0;
        if (exec_en) begin
            unique case (op)
                OP_JMP: begin
                    take  = 1'b1;
                    tgt_d = mword;
                end
                OP_JREL: begin
                    take  = 1'b1;
                    tgt_d = pc + mword;
                end
                OP_LDN:           acc_d   = -mword;
                OP_STO:           dmem_we = 1'b1;
                OP_SUBA, OP_SUBB: acc_d   = acc - mword;
                OP_SKN: begin
                    take  = acc[ADDR_W-1];
                    tgt_d = acc[ADDR_W-1] ? pc + ADDR_W'(1) : tgt_q;
                end
                OP_HALT:          halt_req = 1'b1;
            endcase
        end
    end

    // sole writer of the accumulator and branch-target register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            tgt_q <= '0;
        end else begin
            acc   <= acc_d;
            tgt_q <= tgt_d;
        end
    end

endmodule

// File: rtl/acc_pipe_core.sv
module acc_pipe_core
    import acc_pipe_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_rdata,
    output logic [ADDR_W-1:0] dmem_addr,
    input  logic [WORD_W-1:0] dmem_rdata,
    output logic              dmem_we,
    output logic [WORD_W-1:0] dmem_wdata,
    output logic [ADDR_W-1:0] acc_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic              halted
);

    logic              fetch_en, exec_en, redirect, take, halt_req;
    logic [ADDR_W-1:0] pc, tgt_q, acc;
    logic [WORD_W-1:0] ir;

    acc_pipe_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .halt_req (halt_req),
        .fetch_en (fetch_en),
        .exec_en  (exec_en),
        .redirect (redirect),
        .halted   (halted)
    );

    acc_pipe_fetch #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_en   (fetch_en),
        .redirect   (redirect),
        .tgt        (tgt_q),
        .imem_rdata (imem_rdata),
        .imem_addr  (imem_addr),
        .pc         (pc),
        .ir         (ir)
    );

    acc_pipe_exec #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_en    (exec_en),
        .ir         (ir),
        .pc         (pc),
        .dmem_rdata (dmem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .acc        (acc),
        .tgt_q      (tgt_q),
        .take       (take),
        .halt_req   (halt_req)
    );

    assign acc_out = acc;
    assign pc_out  = pc;

endmodule

// File: rtl/acc_pipe_chk.sv
module acc_pipe_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_en,
    input logic              redirect,
    input logic              take,
    input logic              halted,
    input logic              dmem_we,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] tgt_q,
    input logic [ADDR_W-1:0] acc
);

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !redirect) |=> pc == $past(pc) + ADDR_W'(1));

    p_take_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> redirect);

    p_redirect_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> pc == $past(tgt_q) + ADDR_W'(1));

    p_squash_no_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> !dmem_we);

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(pc) && $stable(acc));

    p_halt_no_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !dmem_we);

endmodule

bind acc_pipe_core acc_pipe_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_en (fetch_en),
    .redirect (redirect),
    .take     (take),
    .halted   (halted),
    .dmem_we  (dmem_we),
    .pc       (pc),
    .tgt_q    (tgt_q),
    .acc      (acc)
);

// File: tb/acc_pipe_core_tb_top.sv
`timescale 1ns/1ps
module acc_pipe_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] imem_addr, dmem_addr, acc_out, pc_out;
    logic [15:0] imem_rdata, dmem_rdata, dmem_wdata;
    logic        dmem_we, halted;

    logic [15:0] mem [0:511];
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign imem_rdata = mem[imem_addr[8:0]];
    assign dmem_rdata = mem[dmem_addr[8:0]];
    always @(posedge clk) if (dmem_we) mem[dmem_addr[8:0]] <= dmem_wdata;

    acc_pipe_core dut_i (
        .clk(clk), .rst_n(rst_n),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
        .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
        .acc_out(acc_out), .pc_out(pc_out), .halted(halted)
    );

    // {operand a, operand b, expected acc, expected stored word}
    localparam logic [63:0] VECS [0:4] = '{
        {16'h0005, 16'h0003, 16'h1FF8, 16'hFFF8},
        {16'h0000, 16'h0000, 16'h0000, 16'h0000},
        {16'h1000, 16'h0001, 16'h0FFF, 16'h0FFF},
        {16'hFFFF, 16'h2002, 16'h1FFF, 16'hFFFF},
        {16'h0007, 16'h1FF9, 16'h0000, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        clear_mem();
    endtask

    // release at a negedge; sample point k=0 is the first cycle out of reset
    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    task automatic run_to_halt(output int cycles);
        cycles = 0;
        while (!halted && cycles < 60) begin
            step();
            cycles++;
        end
    endtask

    initial begin
        int cyc;
        logic [12:0] pc_hold;

        // ---- reset state (R1) ----
        hold_reset();
        mem[0] = 16'h4040; mem[1] = 16'h8041; mem[2] = 16'h6042; mem[3] = 16'hE000;
        #1;
        chk("R1 pc in reset", 32'(pc_out), 0);
        chk("R1 acc in reset", 32'(acc_out), 0);
        chk("R1 halted in reset", 32'(halted), 0);
        release_reset();
        chk("R1 imem_addr first cycle", 32'(imem_addr), 0);
        chk("R1 no store first cycle", 32'(dmem_we), 0);
        step();
        chk("R2 imem_addr step", 32'(imem_addr), 1);
        step();
        chk("R2 imem_addr step", 32'(imem_addr), 2);

        // ---- arithmetic table (R3 R4 R5 R10) ----
        for (int v = 0; v < 5; v++) begin
            hold_reset();
            mem[0] = 16'h4040;                                  // LDN 0x40
            mem[1] = (v % 2 == 0) ? 16'h8041 : 16'hA041;        // SUB 0x41 (100 / 101)
            mem[2] = 16'h6042;                                  // STO 0x42
            mem[3] = 16'hE000;                                  // HALT
            mem[16'h40] = VECS[v][63:48];
            mem[16'h41] = VECS[v][47:32];
            release_reset();
            run_to_halt(cyc);
            chk("R3 R4 acc after LDN/SUB", 32'(acc_out), 32'(VECS[v][28:16]));
            chk("R5 stored word", 32'(mem[16'h42]), 32'(VECS[v][15:0]));
            chk("R10 cycles to halted", cyc, 5);
            chk("R10 pc held at halt+1", 32'(pc_out), 4);
        end

        // ---- halt holds (R10) ----
        pc_hold = pc_out;
        repeat (4) step();
        chk("R10 halted sticky", 32'(halted), 1);
        chk("R10 pc stable", 32'(pc_out), 32'(pc_hold));
        chk("R10 no store", 32'(dmem_we), 0);

        // ---- absolute jump with squash (R6 R9) ----
        hold_reset();
        mem[0] = 16'h4040; mem[1] = 16'h0041; mem[2] = 16'h4043;
        mem[16'h10] = 16'h6044; mem[16'h11] = 16'hE000;
        mem[16'h40] = 16'h0005; mem[16'h41] = 16'h0010; mem[16'h43] = 16'h0001;
        release_reset();
        step(); step(); step();
        chk("R9 redirect fetch addr", 32'(imem_addr), 32'h10);
        chk("R9 no store in redirect", 32'(dmem_we), 0);
        step();
        chk("R9 pc after redirect", 32'(pc_out), 32'h11);
        chk("R5 store strobe", 32'(dmem_we), 1);
        run_to_halt(cyc);
        chk("R6 squashed load has no effect", 32'(acc_out), 32'h1FFB);
        chk("R6 stored after jump", 32'(mem[16'h44]), 32'hFFFB);
        chk("R6 halt pc", 32'(pc_out), 32'h12);

        // ---- relative jump (R7) ----
        hold_reset();
        mem[0] = 16'h4040; mem[1] = 16'h2041; mem[2] = 16'h4043;
        mem[7] = 16'h6044; mem[8] = 16'hE000;
        mem[16'h40] = 16'h0003; mem[16'h41] = 16'h0005; mem[16'h43] = 16'h0001;
        release_reset();
        run_to_halt(cyc);
        chk("R7 relative target store", 32'(mem[16'h44]), 32'hFFFD);
        chk("R7 halt pc", 32'(pc_out), 9);

        // ---- skip taken (R8) ----
        hold_reset();
        mem[0] = 16'h4040; mem[1] = 16'hC000; mem[2] = 16'h4043;
        mem[3] = 16'h6044; mem[4] = 16'hE000;
        mem[16'h40] = 16'h0001; mem[16'h43] = 16'hFFFE;
        release_reset();
        run_to_halt(cyc);
        chk("R8 skip taken acc", 32'(acc_out), 32'h1FFF);
        chk("R8 skip taken store", 32'(mem[16'h44]), 32'hFFFF);
        chk("R8 skip halt pc", 32'(pc_out), 5);

        // ---- skip not taken (R8) ----
        hold_reset();
        mem[0] = 16'h4040; mem[1] = 16'hC000; mem[2] = 16'h4043;
        mem[3] = 16'h6044; mem[4] = 16'hE000;
        mem[16'h40] = 16'hFFFF; mem[16'h43] = 16'hFFFE;
        release_reset();
        run_to_halt(cyc);
        chk("R8 skip not taken acc", 32'(acc_out), 2);
        chk("R8 skip not taken store", 32'(mem[16'h44]), 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule